// File: doc/BRIEF.md
# Unaligned Word Merge Datapath

This block performs the byte-merging step of the four partial-word memory operations that let software reach a word at an address that is not word-aligned. Each operation moves only part of a word: the left and right variants take bytes from opposite ends, and the byte offset inside the aligned word sets how many bytes move. The two load variants combine an aligned memory word with the old register value to form the new register value. The two store variants combine the register value with the current memory word to form the word to be written, and they also give a byte-enable mask for that word.

Byte lanes are numbered little-endian. Lane 0 holds the least significant byte. The operation is chosen by the 6-bit primary opcode field of the instruction. The merge itself is combinational and is followed by one output register stage. The output valid flag follows an accepted input by exactly one clock. Word width is set by a byte count and a byte width, both parameters. The requirements below use the default of four 8-bit bytes, with k the byte offset.

Top module: `umerge_unit`

## Requirements
- R1: While reset is active, and in the first cycle after it, out_valid, out_store, out_data and out_be are all zero.
- R2: Load-left (opcode 0x22): out_data = (mem << s) | (reg & ((1<<s)-1)), with s = 24-8k.
- R3: Load-right (opcode 0x26): out_data = (mem >> s) | (reg & ~(0xFFFFFFFF >> s)), with s = 8k.
- R4: Store-left (opcode 0x2A): out_data = (reg >> s) | (mem & ~(0xFFFFFFFF >> s)), with s = 24-8k.
- R5: Store-right (opcode 0x2E): out_data = (reg << s) | (mem & ((1<<s)-1)), with s = 8k.
- R6: For store-left, out_be has a 1 in bit i exactly for lanes 0 through k.
- R7: For store-right, out_be has a 1 in bit i exactly for lanes k through 3.
- R8: For the two loads, out_be is 0 and out_store is 0. For the two stores, out_store is 1.
- R9: At the boundary offsets the whole word moves. Load-left at k=3 and load-right at k=0 return the memory word unchanged. Store-left at k=3 and store-right at k=0 return the register word with out_be = 4'b1111.
- R10: When in_valid is high with one of the four opcodes at a rising edge, out_valid is high after that edge and the outputs hold that operation's result.
- R11: When in_valid is low, or the opcode is any other value, out_valid is low after the edge and out_data, out_be and out_store keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation request this cycle |
| in_opcode | input | 6 | Primary opcode field of the instruction |
| in_offset | input | IW (2) | Byte offset of the address within the aligned word |
| in_reg | input | DW (32) | Register operand |
| in_mem | input | DW (32) | Aligned memory word |
| out_valid | output | 1 | Registered result is new this cycle |
| out_store | output | 1 | Result is a memory write word (1) or register value (0) |
| out_data | output | DW (32) | Merged word |
| out_be | output | NBYTES (4) | Byte enables for a store, zero for a load |

## Verification
The hardest faults to expose are a byte taken from the wrong lane and a merge boundary that is off by one. Ordinary test data often hides both, because lanes with equal byte values make a misrouted byte look correct. The stimulus therefore gives every byte of the register and memory operands a distinct value, and it sweeps every opcode against every offset under several such patterns, so each lane's source is identified exactly. Rejected opcodes and idle cycles are placed directly after valid results, so a held output can be told apart from a freshly computed one.

// File: rtl/umerge_pkg.sv
package umerge_pkg;

   // Operation kind: bit 1 = store, bit 0 = right variant
   typedef enum logic [1:0] {
      MRG_LOAD_L  = 2'b00,
      MRG_LOAD_R  = 2'b01,
      MRG_STORE_L = 2'b10,
      MRG_STORE_R = 2'b11
   } merge_op_e;

   localparam logic [5:0] OPC_LOAD_L  = 6'h22;
   localparam logic [5:0] OPC_LOAD_R  = 6'h26;
   localparam logic [5:0] OPC_STORE_L = 6'h2A;
   localparam logic [5:0] OPC_STORE_R = 6'h2E;

endpackage

// File: rtl/umerge_decode.sv
module umerge_decode
   import umerge_pkg::*;
(
   input  logic [5:0] opcode,
   output logic       hit,
   output merge_op_e  op
);

   always_comb begin
      hit = 1'b1;
      op  = MRG_LOAD_L;
      unique case (opcode)
         OPC_LOAD_L:  op = MRG_LOAD_L;
         OPC_LOAD_R:  op = MRG_LOAD_R;
         OPC_STORE_L: op = MRG_STORE_L;
         OPC_STORE_R: op = MRG_STORE_R;
         default:     hit = 1'b0;
      endcase
   end

endmodule

// File: rtl/umerge_lanes.sv
module umerge_lanes
   import umerge_pkg::*;
#(
   parameter int NBYTES = 4,
   parameter int BYTE_W = 8,
   localparam int IW = $clog2(NBYTES),
   localparam int DW = NBYTES * BYTE_W
) (
   input  merge_op_e         op,
   input  logic [IW-1:0]     offset,
   input  logic [DW-1:0]     reg_word,
   input  logic [DW-1:0]     mem_word,
   output logic [DW-1:0]     merged,
   output logic [NBYTES-1:0] byte_en
);

   logic [NBYTES-1:0][BYTE_W-1:0] reg_b;
   logic [NBYTES-1:0][BYTE_W-1:0] mem_b;
   logic [NBYTES-1:0][BYTE_W-1:0] out_b;

   assign reg_b  = reg_word;
   assign mem_b  = mem_word;
   assign merged = out_b;

   for (genvar i = 0; i < NBYTES; i++) begin : g_lane
      logic [BYTE_W-1:0] lane_d;
      logic              lane_en;

      always_comb begin
         int k;
         int span;
         k       = int'(offset);
         span    = NBYTES - 1 - k;
         lane_d  = reg_b[i];
         lane_en = 1'b0;
         unique case (op)
            MRG_LOAD_L: begin
               if (i >= span) lane_d = mem_b[IW'(i - span)];
            end
            MRG_LOAD_R: begin
               if (i <= span) lane_d = mem_b[IW'(i + k)];
            end
            MRG_STORE_L: begin
               lane_en = (i <= k);
               lane_d  = (i <= k) ? reg_b[IW'(i + span)] : mem_b[i];
            end
            MRG_STORE_R: begin
               lane_en = (i >= k);
               lane_d  = (i >= k) ? reg_b[IW'(i - k)] : mem_b[i];
            end
            default: lane_d = reg_b[i];
         endcase
      end

      assign out_b[i]   = lane_d;
      assign byte_en[i] = lane_en;
   end

endmodule

// File: rtl/umerge_stage.sv
module umerge_stage #(
   parameter int PW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take,
   input  logic [PW-1:0] d,
   output logic          valid,
   output logic [PW-1:0] q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid <= 1'b0;
         q     <= '0;
      end else begin
         valid <= take;
         if (take) q <= d;
      end
   end

endmodule

// File: rtl/umerge_unit.sv
module umerge_unit
   import umerge_pkg::*;
#(
   parameter int NBYTES = 4,
   parameter int BYTE_W = 8,
   localparam int IW = $clog2(NBYTES),
   localparam int DW = NBYTES * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [5:0]        in_opcode,
   input  logic [IW-1:0]     in_offset,
   input  logic [DW-1:0]     in_reg,
   input  logic [DW-1:0]     in_mem,
   output logic              out_valid,
   output logic              out_store,
   output logic [DW-1:0]     out_data,
   output logic [NBYTES-1:0] out_be
);

   localparam int PW = 1 + DW + NBYTES;

   if (NBYTES < 2 || (NBYTES & (NBYTES - 1)) != 0) begin : g_bad_nbytes
      $error("umerge_unit: NBYTES must be a power of two of at least 2");
   end
   if (BYTE_W < 1) begin : g_bad_bytew
      $error("umerge_unit: BYTE_W must be positive");
   end

   logic              hit;
   merge_op_e         op;
   logic [DW-1:0]     merged;
   logic [NBYTES-1:0] byte_en;
   logic [PW-1:0]     stage_q;

   umerge_decode u_dec (
      .opcode (in_opcode),
      .hit    (hit),
      .op     (op)
   );

   umerge_lanes #(.NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_lanes (
      .op       (op),
      .offset   (in_offset),
      .reg_word (in_reg),
      .mem_word (in_mem),
      .merged   (merged),
      .byte_en  (byte_en)
   );

   umerge_stage #(.PW(PW)) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .take  (in_valid && hit),
      .d     ({op[1], merged, byte_en}),
      .valid (out_valid),
      .q     (stage_q)
   );

   assign out_store = stage_q[PW-1];
   assign out_data  = stage_q[NBYTES +: DW];
   assign out_be    = stage_q[NBYTES-1:0];

endmodule

// File: rtl/umerge_unit_chk.sv
module umerge_unit_chk #(
   parameter int NBYTES = 4,
   parameter int BYTE_W = 8,
   localparam int IW = $clog2(NBYTES),
   localparam int DW = NBYTES * BYTE_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [5:0]        in_opcode,
   input logic [IW-1:0]     in_offset,
   input logic [DW-1:0]     in_reg,
   input logic [DW-1:0]     in_mem,
   input logic              out_valid,
   input logic              out_store,
   input logic [DW-1:0]     out_data,
   input logic [NBYTES-1:0] out_be
);

   logic known;
   assign known = (in_opcode == 6'h22) || (in_opcode == 6'h26) ||
                  (in_opcode == 6'h2A) || (in_opcode == 6'h2E);

   a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && known |=> out_valid);

   a_r11_hold_on_reject: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && known) |=> !out_valid && $stable(out_data) && $stable(out_be) && $stable(out_store));

   a_r8_load_no_enables: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_store |-> out_be == '0);

   a_r6_store_left_be: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_opcode == 6'h2A |=>
         out_be[0] && ($countones(out_be) == int'($past(in_offset)) + 1));

   a_r7_store_right_be: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_opcode == 6'h2E |=>
         out_be[NBYTES-1] && ($countones(out_be) == NBYTES - int'($past(in_offset))));

   a_r9_load_left_full: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_opcode == 6'h22 && in_offset == IW'(NBYTES - 1) |=>
         out_data == $past(in_mem));

   a_r9_store_right_full: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_opcode == 6'h2E && in_offset == '0 |=>
         out_data == $past(in_reg) && out_be == '1);

endmodule

bind umerge_unit umerge_unit_chk #(.NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_opcode (in_opcode),
   .in_offset (in_offset),
   .in_reg    (in_reg),
   .in_mem    (in_mem),
   .out_valid (out_valid),
   .out_store (out_store),
   .out_data  (out_data),
   .out_be    (out_be)
);

// File: tb/umerge_unit_test.sv
module umerge_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [5:0]  in_opcode = '0;
   logic [1:0]  in_offset = '0;
   logic [31:0] in_reg = '0;
   logic [31:0] in_mem = '0;
   logic        out_valid;
   logic        out_store;
   logic [31:0] out_data;
   logic [3:0]  out_be;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #10 clk = ~clk;   // 50 MHz

   umerge_unit uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_opcode(in_opcode),
      .in_offset(in_offset), .in_reg(in_reg), .in_mem(in_mem),
      .out_valid(out_valid), .out_store(out_store), .out_data(out_data), .out_be(out_be)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 20000) begin
         errors = errors + 1;
         checks = checks + 1;
         $display("FAIL watchdog: run did not finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         errors = errors + 1;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] lo_mask(input int s);
      logic [63:0] m;
      m = (64'd1 << s) - 64'd1;
      return m[31:0];
   endfunction

   logic [31:0] last_data;
   logic [3:0]  last_be;
   logic        last_store;

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1 valid", 64'(out_valid), 64'd0);
      check("R1 data", 64'(out_data), 64'd0);
      check("R1 be/store", 64'({out_be, out_store}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", 64'({out_valid, out_be, out_data}), 64'd0);

      for (int p = 0; p < 6; p++) begin
         for (int o = 0; o < 4; o++) begin
            for (int k = 0; k < 4; k++) begin
               logic [31:0] rv, mv, exp_d;
               logic [3:0]  exp_be;
               logic [5:0]  opc;
               string       tag;
               int          s;
               rv = 32'h0102_0304 + 32'(p) * 32'h1010_1010;
               mv = 32'hA1B2_C3D4 ^ (32'(p) * 32'h0505_0505);
               if (p == 5) begin rv = 32'hFFFF_FFFF; mv = 32'h0000_0000; end
               exp_be = 4'h0;
               case (o)
                  0: begin opc = 6'h22; s = 24 - 8*k; tag = "R2";
                     exp_d = (mv << s) | (rv & lo_mask(s)); end
                  1: begin opc = 6'h26; s = 8*k; tag = "R3";
                     exp_d = (mv >> s) | (rv & ~(32'hFFFF_FFFF >> s)); end
                  2: begin opc = 6'h2A; s = 24 - 8*k; tag = "R4";
                     exp_d = (rv >> s) | (mv & ~(32'hFFFF_FFFF >> s));
                     exp_be = 4'(lo_mask(k + 1)); end
                  default: begin opc = 6'h2E; s = 8*k; tag = "R5";
                     exp_d = (rv << s) | (mv & lo_mask(s));
                     exp_be = 4'((32'hF << k) & 32'hF); end
               endcase
               if ((o == 0 && k == 3) || (o == 1 && k == 0)) begin
                  tag = "R9 load full"; exp_d = mv;
               end
               if ((o == 2 && k == 3) || (o == 3 && k == 0)) begin
                  tag = "R9 store full"; exp_d = rv; exp_be = 4'hF;
               end
               in_valid = 1'b1; in_opcode = opc; in_offset = 2'(k);
               in_reg = rv; in_mem = mv;
               @(negedge clk);
               check(tag, 64'(out_data), 64'(exp_d));
               check("R10 valid", 64'(out_valid), 64'd1);
               if (o == 2) check("R6 be", 64'(out_be), 64'(exp_be));
               else if (o == 3) check("R7 be", 64'(out_be), 64'(exp_be));
               else check("R8 load be", 64'(out_be), 64'd0);
               check("R8 store flag", 64'(out_store), 64'(o >= 2));
            end
         end
      end

      // R11: rejected opcodes and idle cycles hold the last result
      last_data = out_data; last_be = out_be; last_store = out_store;
      for (int j = 0; j < 6; j++) begin
         logic [5:0] bad;
         case (j)
            0: bad = 6'h23;
            1: bad = 6'h20;
            2: bad = 6'h2B;
            3: bad = 6'h00;
            4: bad = 6'h3A;
            default: bad = 6'h26;
         endcase
         in_valid = (j != 5); in_opcode = bad; in_offset = 2'd1;
         in_reg = 32'hDEAD_BEEF; in_mem = 32'h1234_5678;
         @(negedge clk);
         check("R11 valid low", 64'(out_valid), 64'd0);
         check("R11 hold", 64'({out_store, out_be, out_data}),
               64'({last_store, last_be, last_data}));
      end

      // R10 then R11: one accepted, then drop valid
      in_valid = 1'b1; in_opcode = 6'h2E; in_offset = 2'd2;
      in_reg = 32'h0A0B_0C0D; in_mem = 32'h1111_2222;
      @(negedge clk);
      check("R10 single", 64'({out_valid, out_be, out_data}),
            64'({1'b1, 4'hC, 32'h0C0D_2222}));
      in_valid = 1'b0;
      @(negedge clk);
      check("R11 after drop", 64'({out_valid, out_data}), 64'({1'b0, 32'h0C0D_2222}));

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule